// File: doc/BRIEF.md
# Quadrature Pulse Counter with Tagged Compare Table

This block counts pulses from two already synchronized phase inputs and a reference-mark input. It keeps a 32-bit position value. A static mode input selects one of four ways to turn the phase inputs into count steps:

- 4x quadrature
- pulse with a direction level
- separate up and down pulse lines
- a single up-only line

The value either saturates at the signed 32-bit limits and sets sticky limit flags, or circulates between zero and a programmed ceiling. A software request or a rising reference mark clears it, depending on the selected reset policy.

A comparison engine watches the count once it has been started. In list mode it steps through a table of target values, and each entry carries an 8-bit event tag. When the count equals the entry currently armed, it emits that tag and arms the next entry. In window mode it holds up to eight signed lower/upper pairs. It drives one in-window flag per pair and emits the pair's tag whenever the count moves into that pair's window.

All tables, the ring ceiling and a count preset are loaded through one write port with a selector field.

Top module: `pulse_tally`

## Requirements
- R1: With `dec_mode`=0, every single-input change of `in_a` or `in_b` moves the count by one. Going 00→10→11→01→00 on {a,b} counts up, and the reverse order counts down. A cycle in which both inputs change does not move the count.
- R2: With `dec_mode`=1, each rising edge of `in_a` counts up when `in_b` is 1 and down when it is 0. Falling edges of `in_a` do not count.
- R3: With `dec_mode`=2, a rising `in_a` counts up and a rising `in_b` counts down. When both rise in the same cycle, the count does not change.
- R4: With `dec_mode`=3, a rising `in_a` counts up and `in_b` has no effect.
- R5: With `ring_en`=0, an up step at 0x7FFFFFFF holds the value and sets `ovf_flag`. A down step at 0x80000000 holds the value and sets `unf_flag`. Both flags stay set until the count is cleared by a reset request.
- R6: With `ring_en`=1, an up step at the ceiling goes to 0 and a down step at 0 goes to the ceiling.
- R7: `sw_reset` clears the count and both flags under every `rst_method`. A rising `in_z` clears them under methods 0 and 2 and is ignored under method 1. Under method 0, the rising `in_z` also stops the compare engine; under method 2, the engine keeps running.
- R8: When a clear (software or reference mark) falls in the same cycle as a count step or a preset write, the result is 0. A preset write wins over a count step in the same cycle.
- R9: In list mode (`cmp_range_mode`=0), `match_valid` pulses for one cycle, with the armed entry's tag, in the cycle after the count equals that entry. The next entry is then armed, and after the last valid entry the list wraps to entry 0. `cmp_start` re-arms entry 0.
- R10: In window mode, `range_hit[i]` is 1 in the cycle after the count lies within lower..upper (inclusive, signed). A window that turns on emits its tag on `match_valid`; when several turn on together, the lowest index wins.
- R11: `cmp_active` goes high the cycle after `cmp_start` and low the cycle after `cmp_stop`. While it is low, `match_valid` and `range_hit` stay 0.
- R12: The write port stores `wr_data` at `wr_addr` for these `wr_sel` codes:
  - 0: target value
  - 1: target tag
  - 2: window lower
  - 3: window upper
  - 4: window tag
  - 5: number of valid targets
  - 6: ring ceiling
  - 7: count preset, visible on `count` the next cycle

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_a | input | 1 | Phase A / count pulse / up pulse |
| in_b | input | 1 | Phase B / direction / down pulse |
| in_z | input | 1 | Reference mark, acts on rising edge |
| dec_mode | input | 2 | Input decoding select (R1–R4 codes) |
| ring_en | input | 1 | 1 = ring counting, 0 = saturating linear |
| rst_method | input | 2 | Clear policy: 0 mark+sw, 1 sw only, 2 mark+sw keeping compare |
| sw_reset | input | 1 | Software clear request |
| cmp_start | input | 1 | Start compare, arm entry 0 |
| cmp_stop | input | 1 | Stop compare |
| cmp_range_mode | input | 1 | 1 = window mode, 0 = list mode |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_addr | input | 6 | Table index |
| wr_data | input | 32 | Write data |
| count | output | 32 | Current count |
| ovf_flag | output | 1 | Sticky upper-limit flag |
| unf_flag | output | 1 | Sticky lower-limit flag |
| cmp_active | output | 1 | Compare engine running |
| match_valid | output | 1 | One-cycle match event |
| match_tag | output | 8 | Tag of the event |
| range_hit | output | 8 | Per-window in-range flags |

## Verification
The cycle that matters is one in which a clear request lands together with a count step or a preset. The bench provokes it by raising `sw_reset` and a counting edge on `in_a` at the same falling clock edge, and then by pairing a preset write with a step. It judges the outcome from `count` one cycle later, expecting 0 and the preset value respectively.

A second collision tested is a preset that pushes the count into two windows at once. Here only the lower-index tag may appear on `match_tag`, while both `range_hit` bits rise.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;

   typedef enum logic [1:0] {
      DEC_QUAD   = 2'd0,
      DEC_PDIR   = 2'd1,
      DEC_UPDN   = 2'd2,
      DEC_SINGLE = 2'd3
   } dec_mode_e;

   typedef enum logic [1:0] {
      CLR_MARK_HALT = 2'd0,
      CLR_SW_ONLY   = 2'd1,
      CLR_MARK_KEEP = 2'd2,
      CLR_RSVD      = 2'd3
   } clr_policy_e;

   localparam logic [2:0] WS_TGT_VAL  = 3'd0;
   localparam logic [2:0] WS_TGT_TAG  = 3'd1;
   localparam logic [2:0] WS_WIN_LO   = 3'd2;
   localparam logic [2:0] WS_WIN_HI   = 3'd3;
   localparam logic [2:0] WS_WIN_TAG  = 3'd4;
   localparam logic [2:0] WS_TGT_NUM  = 3'd5;
   localparam logic [2:0] WS_RING_MAX = 3'd6;
   localparam logic [2:0] WS_PRESET   = 3'd7;

endpackage

// File: rtl/pulse_tally_dec.sv
module pulse_tally_dec
   import pulse_tally_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_a,
   input  logic       in_b,
   input  logic [1:0] mode,
   output logic       step_up,
   output logic       step_dn
);

   logic a_p, b_p;
   logic a_chg, b_chg, a_rise, b_rise;
   dec_mode_e mode_e;

   assign mode_e = dec_mode_e'(mode);
   assign a_chg  = in_a ^ a_p;
   assign b_chg  = in_b ^ b_p;
   assign a_rise = in_a & ~a_p;
   assign b_rise = in_b & ~b_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_p <= 1'b0;
         b_p <= 1'b0;
      end else begin
         a_p <= in_a;
         b_p <= in_b;
      end
   end

   always_comb begin
      step_up = 1'b0;
      step_dn = 1'b0;
      unique case (mode_e)
         DEC_QUAD: begin
            if (a_chg ^ b_chg) begin
               step_up = in_a ^ b_p;
               step_dn = ~(in_a ^ b_p);
            end
         end
         DEC_PDIR: begin
            step_up = a_rise & in_b;
            step_dn = a_rise & ~in_b;
         end
         DEC_UPDN: begin
            step_up = a_rise & ~b_rise;
            step_dn = b_rise & ~a_rise;
         end
         DEC_SINGLE: begin
            step_up = a_rise;
         end
         default: ;
      endcase
   end

   // R1: quadrature decoding never yields both directions at once
   AST_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_up && step_dn)); // R1

   // R4: single-phase decoding never counts down
   AST_SINGLE_NO_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == DEC_SINGLE) |-> !step_dn); // R4

endmodule

// File: rtl/pulse_tally_core.sv
module pulse_tally_core
   import pulse_tally_pkg::*;
#(
   parameter int CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             in_z,
   input  logic             ring_en,
   input  logic [1:0]       rst_method,
   input  logic             sw_reset,
   input  logic             ring_max_we,
   input  logic             preset_we,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q,
   output logic             unf_q,
   output logic             z_halt
);

   localparam logic [CNT_W-1:0] MAX_POS = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic [CNT_W-1:0] MIN_NEG = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             z_p;
   logic             z_rise;
   logic             clr;
   logic [CNT_W-1:0] ring_max_q;
   clr_policy_e      pol;

   assign pol    = clr_policy_e'(rst_method);
   assign z_rise = in_z & ~z_p;
   assign clr    = sw_reset | (z_rise & ((pol == CLR_MARK_HALT) | (pol == CLR_MARK_KEEP)));
   assign z_halt = z_rise & (pol == CLR_MARK_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_p        <= 1'b0;
         ring_max_q <= '1;
      end else begin
         z_p <= in_z;
         if (ring_max_we) ring_max_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else if (preset_we) begin
         cnt_q <= wr_data;
      end else if (step_up) begin
         if (ring_en) begin
            cnt_q <= (cnt_q >= ring_max_q) ? '0 : cnt_q + ONE;
         end else if (cnt_q == MAX_POS) begin
            ovf_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end else if (step_dn) begin
         if (ring_en) begin
            cnt_q <= (cnt_q == '0) ? ring_max_q : cnt_q - ONE;
         end else if (cnt_q == MIN_NEG) begin
            unf_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   // In linear mode the count moves by exactly one unless cleared or preset
   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && !$past(preset_we) && !$past(ring_en) && (cnt_q != $past(cnt_q)))
      |-> (((cnt_q - $past(cnt_q)) == ONE) || (($past(cnt_q) - cnt_q) == ONE))); // R5

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf_q) && !$past(clr)) |-> ovf_q); // R5

   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(unf_q) && !$past(clr)) |-> unf_q); // R5

   AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_en && $past(ring_en) && !$past(ring_max_we) && !$past(preset_we)
       && ($past(cnt_q) <= ring_max_q)) |-> (cnt_q <= ring_max_q)); // R6

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (cnt_q == '0 && !ovf_q && !unf_q)); // R8

endmodule

// File: rtl/pulse_tally_cmp.sv
module pulse_tally_cmp
   import pulse_tally_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int TGT_DEPTH = 48,
   parameter int RNG_NUM   = 8,
   parameter int TAG_W     = 8,
   parameter int ADDR_W    = 6
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   cnt,
   input  logic               start,
   input  logic               stop,
   input  logic               range_mode,
   input  logic               wr_en,
   input  logic [2:0]         wr_sel,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   output logic               run_q,
   output logic               match_valid,
   output logic [TAG_W-1:0]   match_tag,
   output logic [RNG_NUM-1:0] range_hit
);

   localparam int              RNG_AW  = $clog2(RNG_NUM);
   localparam logic [ADDR_W:0] NUM_MAX = (ADDR_W+1)'(TGT_DEPTH);
   localparam logic [ADDR_W:0] ONE_P   = {{ADDR_W{1'b0}}, 1'b1};

   logic [CNT_W-1:0]  tgt_val [TGT_DEPTH];
   logic [TAG_W-1:0]  tgt_tag [TGT_DEPTH];
   logic [CNT_W-1:0]  win_lo  [RNG_NUM];
   logic [CNT_W-1:0]  win_hi  [RNG_NUM];
   logic [TAG_W-1:0]  win_tag [RNG_NUM];
   logic [ADDR_W:0]   tgt_num_q;
   logic [ADDR_W-1:0] ptr_q;

   logic               ptr_ok, ptr_last, tgt_hit;
   logic [RNG_NUM-1:0] win_in, hit_d, enter;
   logic [RNG_AW-1:0]  enc;

   // ---------------- table writes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TGT_DEPTH; i++) begin
            tgt_val[i] <= '0;
            tgt_tag[i] <= '0;
         end
         for (int j = 0; j < RNG_NUM; j++) begin
            win_lo[j]  <= '0;
            win_hi[j]  <= '1;
            win_tag[j] <= '0;
         end
         tgt_num_q <= '0;
      end else if (wr_en) begin
         unique case (wr_sel)
            WS_TGT_VAL: if (int'(wr_addr) < TGT_DEPTH) tgt_val[wr_addr] <= wr_data;
            WS_TGT_TAG: if (int'(wr_addr) < TGT_DEPTH) tgt_tag[wr_addr] <= wr_data[TAG_W-1:0];
            WS_WIN_LO:  if (int'(wr_addr) < RNG_NUM) win_lo[wr_addr[RNG_AW-1:0]] <= wr_data;
            WS_WIN_HI:  if (int'(wr_addr) < RNG_NUM) win_hi[wr_addr[RNG_AW-1:0]] <= wr_data;
            WS_WIN_TAG: if (int'(wr_addr) < RNG_NUM) win_tag[wr_addr[RNG_AW-1:0]] <= wr_data[TAG_W-1:0];
            WS_TGT_NUM: tgt_num_q <= (wr_data[ADDR_W:0] > NUM_MAX) ? NUM_MAX : wr_data[ADDR_W:0];
            default: ;
         endcase
      end
   end

   // ---------------- list compare ----------------
   assign ptr_ok   = ({1'b0, ptr_q} < tgt_num_q);
   assign ptr_last = (({1'b0, ptr_q} + ONE_P) >= tgt_num_q);
   assign tgt_hit  = run_q && !stop && !start && !range_mode && ptr_ok
                     && (cnt == tgt_val[ptr_q]);

   // ---------------- window compare ----------------
   for (genvar w = 0; w < RNG_NUM; w++) begin : g_win
      assign win_in[w] = ($signed(cnt) >= $signed(win_lo[w]))
                      && ($signed(cnt) <= $signed(win_hi[w]));
      assign hit_d[w]  = run_q && !stop && range_mode && win_in[w];
   end

   assign enter = hit_d & ~range_hit;

   always_comb begin
      enc = '0;
      for (int k = RNG_NUM - 1; k >= 0; k--) begin
         if (enter[k]) enc = RNG_AW'(k);
      end
   end

   // ---------------- state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         ptr_q       <= '0;
         range_hit   <= '0;
         match_valid <= 1'b0;
         match_tag   <= '0;
      end else begin
         if (stop)       run_q <= 1'b0;
         else if (start) run_q <= 1'b1;

         if (start || !ptr_ok) ptr_q <= '0;
         else if (tgt_hit)     ptr_q <= ptr_last ? '0 : ptr_q + 1'b1;

         range_hit   <= hit_d;
         match_valid <= tgt_hit | (|enter);
         if (tgt_hit)     match_tag <= tgt_tag[ptr_q];
         else if (|enter) match_tag <= win_tag[enc];
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_q) |-> (!match_valid && (range_hit == '0))); // R11

   AST_LIST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (match_valid && !$past(range_mode) && !$past(start) && ($past(tgt_num_q) > ONE_P))
      |-> (ptr_q != $past(ptr_q))); // R9

   AST_WIN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (match_valid && $past(range_mode)) |-> ((range_hit & ~$past(range_hit)) != '0)); // R10

endmodule

// File: rtl/pulse_tally.sv
module pulse_tally
   import pulse_tally_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int TGT_DEPTH = 48,
   parameter int RNG_NUM   = 8,
   parameter int TAG_W     = 8,
   parameter int ADDR_W    = 6
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_a,
   input  logic               in_b,
   input  logic               in_z,
   input  logic [1:0]         dec_mode,
   input  logic               ring_en,
   input  logic [1:0]         rst_method,
   input  logic               sw_reset,
   input  logic               cmp_start,
   input  logic               cmp_stop,
   input  logic               cmp_range_mode,
   input  logic               wr_en,
   input  logic [2:0]         wr_sel,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   output logic [CNT_W-1:0]   count,
   output logic               ovf_flag,
   output logic               unf_flag,
   output logic               cmp_active,
   output logic               match_valid,
   output logic [TAG_W-1:0]   match_tag,
   output logic [RNG_NUM-1:0] range_hit
);

   if (CNT_W < 8 || CNT_W > 64) begin : g_bad_cnt_w
      $error("pulse_tally: CNT_W out of supported range");
   end
   if (TGT_DEPTH < 1 || TGT_DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("pulse_tally: TGT_DEPTH does not fit ADDR_W");
   end
   if (RNG_NUM < 2 || RNG_NUM > (1 << ADDR_W)) begin : g_bad_rng
      $error("pulse_tally: RNG_NUM out of supported range");
   end
   if (TAG_W < 1 || TAG_W > CNT_W) begin : g_bad_tag
      $error("pulse_tally: TAG_W out of supported range");
   end

   logic step_up, step_dn, z_halt;
   logic ring_max_we, preset_we;

   assign ring_max_we = wr_en && (wr_sel == WS_RING_MAX);
   assign preset_we   = wr_en && (wr_sel == WS_PRESET);

   pulse_tally_dec u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_a    (in_a),
      .in_b    (in_b),
      .mode    (dec_mode),
      .step_up (step_up),
      .step_dn (step_dn)
   );

   pulse_tally_core #(.CNT_W(CNT_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_up     (step_up),
      .step_dn     (step_dn),
      .in_z        (in_z),
      .ring_en     (ring_en),
      .rst_method  (rst_method),
      .sw_reset    (sw_reset),
      .ring_max_we (ring_max_we),
      .preset_we   (preset_we),
      .wr_data     (wr_data),
      .cnt_q       (count),
      .ovf_q       (ovf_flag),
      .unf_q       (unf_flag),
      .z_halt      (z_halt)
   );

   pulse_tally_cmp #(
      .CNT_W     (CNT_W),
      .TGT_DEPTH (TGT_DEPTH),
      .RNG_NUM   (RNG_NUM),
      .TAG_W     (TAG_W),
      .ADDR_W    (ADDR_W)
   ) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt         (count),
      .start       (cmp_start),
      .stop        (cmp_stop | z_halt),
      .range_mode  (cmp_range_mode),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .run_q       (cmp_active),
      .match_valid (match_valid),
      .match_tag   (match_tag),
      .range_hit   (range_hit)
   );

   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_stop || z_halt) |=> !cmp_active); // R7

endmodule

// File: tb/pulse_tally_tb.sv
module pulse_tally_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_a, in_b, in_z;
   logic [1:0]  dec_mode, rst_method;
   logic        ring_en, sw_reset, cmp_start, cmp_stop, cmp_range_mode;
   logic        wr_en;
   logic [2:0]  wr_sel;
   logic [5:0]  wr_addr;
   logic [31:0] wr_data;
   logic [31:0] count;
   logic        ovf_flag, unf_flag, cmp_active, match_valid;
   logic [7:0]  match_tag, range_hit;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pulse_tally u_dut (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_z(in_z),
      .dec_mode(dec_mode), .ring_en(ring_en), .rst_method(rst_method),
      .sw_reset(sw_reset), .cmp_start(cmp_start), .cmp_stop(cmp_stop),
      .cmp_range_mode(cmp_range_mode), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
      .ovf_flag(ovf_flag), .unf_flag(unf_flag), .cmp_active(cmp_active),
      .match_valid(match_valid), .match_tag(match_tag), .range_hit(range_hit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic nclk(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [5:0] addr, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = d;
      nclk();
      wr_en = 1'b0;
   endtask

   task automatic ab(input logic a, input logic b);
      in_a = a; in_b = b;
      nclk();
   endtask

   // rising A with direction; match for the new count is visible on return
   task automatic pulse_dir(input logic up);
      in_b = up; in_a = 1'b1;
      nclk();
      in_a = 1'b0;
      nclk();
   endtask

   task automatic swrst();
      sw_reset = 1'b1; nclk(); sw_reset = 1'b0;
   endtask

   task automatic start_cmp();
      cmp_start = 1'b1; nclk(); cmp_start = 1'b0;
   endtask

   task automatic stop_cmp();
      cmp_stop = 1'b1; nclk(); cmp_stop = 1'b0;
   endtask

   task automatic z_pulse();
      in_z = 1'b1; nclk(); in_z = 1'b0; nclk();
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic t_reset_state();
      chk("R12 reset count", count, 32'd0);
      chk("R5 reset flags", {30'd0, ovf_flag, unf_flag}, 32'd0);
      chk("R11 reset idle", {23'd0, cmp_active, match_valid, range_hit}, 32'd0);
   endtask

   task automatic t_quad();
      dec_mode = 2'd0; swrst();
      ab(1'b1, 1'b0); ab(1'b1, 1'b1); ab(1'b0, 1'b1); ab(1'b0, 1'b0);
      chk("R1 quad up x4", count, 32'd4);
      ab(1'b0, 1'b1);
      chk("R1 quad single down step", count, 32'd3);
      ab(1'b1, 1'b1); ab(1'b1, 1'b0); ab(1'b0, 1'b0);
      chk("R1 quad back to zero", count, 32'd0);
      ab(1'b1, 1'b1);
      chk("R1 quad both change ignored", count, 32'd0);
      ab(1'b0, 1'b0);
      chk("R1 quad both change ignored 2", count, 32'd0);
   endtask

   task automatic t_pdir();
      dec_mode = 2'd1; swrst();
      repeat (3) pulse_dir(1'b1);
      chk("R2 pulse dir up", count, 32'd3);
      repeat (2) pulse_dir(1'b0);
      chk("R2 pulse dir down", count, 32'd1);
   endtask

   task automatic t_updn();
      dec_mode = 2'd2; swrst();
      ab(1'b1, 1'b0); ab(1'b0, 1'b0); ab(1'b1, 1'b0); ab(1'b0, 1'b0);
      chk("R3 up pulses", count, 32'd2);
      ab(1'b0, 1'b1); ab(1'b0, 1'b0);
      chk("R3 down pulse", count, 32'd1);
      ab(1'b1, 1'b1);
      chk("R3 simultaneous rises cancel", count, 32'd1);
      ab(1'b0, 1'b0);
   endtask

   task automatic t_single();
      dec_mode = 2'd3; swrst();
      ab(1'b0, 1'b1); ab(1'b0, 1'b0); ab(1'b0, 1'b1); ab(1'b0, 1'b0);
      chk("R4 B ignored", count, 32'd0);
      ab(1'b1, 1'b0); ab(1'b0, 1'b0); ab(1'b1, 1'b1); ab(1'b0, 1'b0);
      chk("R4 A counts up", count, 32'd2);
   endtask

   task automatic t_linear();
      ring_en = 1'b0; dec_mode = 2'd1; swrst();
      wr(3'd7, 6'd0, 32'h7FFF_FFFE);
      chk("R12 preset readback", count, 32'h7FFF_FFFE);
      pulse_dir(1'b1);
      chk("R5 reach max", count, 32'h7FFF_FFFF);
      chk("R5 no ovf at max", {31'd0, ovf_flag}, 32'd0);
      pulse_dir(1'b1);
      chk("R5 hold at max", count, 32'h7FFF_FFFF);
      chk("R5 ovf set", {31'd0, ovf_flag}, 32'd1);
      wr(3'd7, 6'd0, 32'd5);
      chk("R5 ovf sticky across preset", {31'd0, ovf_flag}, 32'd1);
      swrst();
      chk("R5 clear flags", {30'd0, ovf_flag, unf_flag}, 32'd0);
      wr(3'd7, 6'd0, 32'h8000_0001);
      pulse_dir(1'b0);
      chk("R5 reach min", count, 32'h8000_0000);
      pulse_dir(1'b0);
      chk("R5 hold at min", count, 32'h8000_0000);
      chk("R5 unf set", {31'd0, unf_flag}, 32'd1);
      swrst();
   endtask

   task automatic t_ring();
      ring_en = 1'b1; dec_mode = 2'd1;
      wr(3'd6, 6'd0, 32'd3);
      swrst();
      repeat (3) pulse_dir(1'b1);
      chk("R6 up to ceiling", count, 32'd3);
      pulse_dir(1'b1);
      chk("R6 wrap to zero", count, 32'd0);
      pulse_dir(1'b0);
      chk("R6 wrap to ceiling", count, 32'd3);
      ring_en = 1'b0; swrst();
   endtask

   task automatic t_rst_methods();
      cmp_range_mode = 1'b0;
      rst_method = 2'd1;
      wr(3'd7, 6'd0, 32'd9);
      z_pulse();
      chk("R7 method1 mark ignored", count, 32'd9);
      swrst();
      chk("R7 method1 sw clears", count, 32'd0);
      rst_method = 2'd0;
      wr(3'd7, 6'd0, 32'd9);
      start_cmp();
      chk("R11 start raises active", {31'd0, cmp_active}, 32'd1);
      z_pulse();
      chk("R7 method0 mark clears", count, 32'd0);
      chk("R7 method0 mark stops compare", {31'd0, cmp_active}, 32'd0);
      rst_method = 2'd2;
      wr(3'd7, 6'd0, 32'd9);
      start_cmp();
      z_pulse();
      chk("R7 method2 mark clears", count, 32'd0);
      chk("R7 method2 compare keeps running", {31'd0, cmp_active}, 32'd1);
      stop_cmp();
      chk("R11 stop drops active", {31'd0, cmp_active}, 32'd0);
   endtask

   task automatic t_collide();
      dec_mode = 2'd3;
      wr(3'd7, 6'd0, 32'd7);
      sw_reset = 1'b1; in_a = 1'b1;
      nclk();
      sw_reset = 1'b0;
      chk("R8 clear beats step", count, 32'd0);
      in_a = 1'b0; nclk();
      in_a = 1'b1;
      wr(3'd7, 6'd0, 32'd100);
      chk("R8 preset beats step", count, 32'd100);
      in_a = 1'b0; nclk();
      sw_reset = 1'b1;
      wr(3'd7, 6'd0, 32'd55);
      sw_reset = 1'b0;
      chk("R8 clear beats preset", count, 32'd0);
   endtask

   task automatic t_target();
      dec_mode = 2'd1; cmp_range_mode = 1'b0; rst_method = 2'd1;
      swrst();
      wr(3'd0, 6'd0, 32'd2); wr(3'd1, 6'd0, 32'd10);
      wr(3'd0, 6'd1, 32'd3); wr(3'd1, 6'd1, 32'd11);
      wr(3'd0, 6'd2, 32'd1); wr(3'd1, 6'd2, 32'd12);
      wr(3'd5, 6'd0, 32'd3);
      start_cmp();
      pulse_dir(1'b1);
      chk("R9 no match before armed value", {31'd0, match_valid}, 32'd0);
      pulse_dir(1'b1);
      chk("R9 match entry0", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd10});
      nclk();
      chk("R9 match is one cycle", {31'd0, match_valid}, 32'd0);
      pulse_dir(1'b1);
      chk("R9 match entry1", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd11});
      pulse_dir(1'b0);
      chk("R9 passed entry not rematched", {31'd0, match_valid}, 32'd0);
      pulse_dir(1'b0);
      chk("R9 match entry2", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd12});
      pulse_dir(1'b1);
      chk("R9 wrap to entry0", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd10});
   endtask

   task automatic t_disabled();
      stop_cmp();
      swrst();
      for (int i = 0; i < 4; i++) begin
         pulse_dir(1'b1);
         chk("R11 no match while stopped", {31'd0, match_valid}, 32'd0);
      end
      cmp_range_mode = 1'b1;
      wr(3'd2, 6'd0, 32'd0); wr(3'd3, 6'd0, 32'd10);
      nclk();
      chk("R11 no window flags while stopped", {24'd0, range_hit}, 32'd0);
   endtask

   task automatic t_range();
      dec_mode = 2'd1; cmp_range_mode = 1'b1;
      wr(3'd2, 6'd0, 32'd5); wr(3'd3, 6'd0, 32'd7); wr(3'd4, 6'd0, 32'd20);
      wr(3'd2, 6'd1, 32'd6); wr(3'd3, 6'd1, 32'd9); wr(3'd4, 6'd1, 32'd21);
      wr(3'd7, 6'd0, 32'd4);
      start_cmp();
      nclk();
      chk("R10 below windows", {24'd0, range_hit}, 32'd0);
      pulse_dir(1'b1);
      chk("R10 lower bound inclusive", {24'd0, range_hit}, 32'h01);
      chk("R10 enter window0 tag", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd20});
      pulse_dir(1'b1);
      chk("R10 overlap", {24'd0, range_hit}, 32'h03);
      chk("R10 enter window1 tag", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd21});
      pulse_dir(1'b1);
      chk("R10 upper bound inclusive", {24'd0, range_hit}, 32'h03);
      chk("R10 no event when staying", {31'd0, match_valid}, 32'd0);
      pulse_dir(1'b1);
      chk("R10 left window0", {24'd0, range_hit}, 32'h02);
      pulse_dir(1'b0);
      chk("R10 re-enter window0", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd20});
      wr(3'd7, 6'd0, 32'd0);
      nclk();
      chk("R10 outside both", {24'd0, range_hit}, 32'd0);
      wr(3'd7, 6'd0, 32'd6);
      nclk();
      chk("R10 both windows on", {24'd0, range_hit}, 32'h03);
      chk("R10 lowest index wins", {23'd0, match_valid, match_tag}, {23'd0, 1'b1, 8'd20});
      wr(3'd7, 6'd0, 32'hFFFF_FFFE);
      nclk();
      chk("R10 signed negative outside", {24'd0, range_hit}, 32'd0);
      stop_cmp();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
   end

   initial begin
      rst_n = 1'b0;
      in_a = 1'b0; in_b = 1'b0; in_z = 1'b0;
      dec_mode = 2'd0; rst_method = 2'd1; ring_en = 1'b0;
      sw_reset = 1'b0; cmp_start = 1'b0; cmp_stop = 1'b0; cmp_range_mode = 1'b0;
      wr_en = 1'b0; wr_sel = 3'd0; wr_addr = 6'd0; wr_data = 32'd0;
      nclk(3);
      rst_n = 1'b1;
      nclk();
      t_reset_state();
      t_quad();
      t_pdir();
      t_updn();
      t_single();
      t_linear();
      t_ring();
      t_rst_methods();
      t_collide();
      t_target();
      t_disabled();
      t_range();
      report();
   end

endmodule